// File: doc/BRIEF.md
# Return Target Predictor with Call Discovery Stack

This block predicts where a return branch will go on a machine whose instruction set has no dedicated call or return opcodes. Any branch may act as a call in one execution and as a return in another. The front end reports each resolved taken branch that could be a call. For each one, the block records the callee target and the computed return address on a small circular discovery stack. It also reports each resolved branch that could be a return, along with that branch's actual target.

When a possible return lands on a return address that is held on the stack, the block does two things. It pops the matching record and every record above it. It also writes the branch's address into a direct-mapped return cache, which marks that branch as one that behaves like a return. A fetch-side lookup of a branch that hits in the return cache predicts the return address of the current stack top. The lookup also shows the callee target of that record. Deciding which branches are eligible is left to the surrounding logic, and so is direction prediction.

Top module: `call_ret_predictor`

## Requirements
- R1: The return address of a possible call is `call_pc_i + call_len_i`, where `call_len_i` carries the instruction length as a byte count. The legal values are 2, 4 and 6.
- R2: A possible call pushes a record holding its return address and its target. From the next cycle, a lookup hit reports that return address on `lkp_tgt_o` and that target on `lkp_fn_o`.
- R3: The stack holds 8 records and is circular. A ninth push without a pop overwrites the oldest record, so a return to that oldest return address no longer matches and leaves the stack unchanged.
- R4: A possible return is compared with the stored return addresses starting from the top of the stack, and the topmost match wins. The matching record and every record above it are removed, so the record just below the match becomes the new top.
- R5: A matching return writes a return cache entry for its branch address, and later lookups of that address hit. A return that matches no record writes nothing and leaves the stack unchanged.
- R6: The return cache has 16 direct-mapped entries. It is indexed by address bits [4:1] and tagged by all the remaining bits. A lookup of an address that shares the index but has a different tag misses. A newer write to the same index replaces the older entry.
- R7: A lookup reports no prediction (`lkp_hit_o` low) while the stack is empty, even if the return cache holds a matching entry.
- R8: When a call and a return resolve in the same cycle, the return match and its pop are applied first, and then the call is pushed.
- R9: `flush_i` empties the stack and invalidates every return cache entry. It overrides any call or return presented in the same cycle.
- R10: After reset the stack and the return cache are empty, and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Empty the stack and the return cache |
| call_vld_i | input | 1 | A possible call has resolved taken |
| call_pc_i | input | ADDR_W | Address of the possible call |
| call_len_i | input | 3 | Length of the call instruction in bytes (2, 4 or 6) |
| call_tgt_i | input | ADDR_W | Target of the possible call |
| ret_vld_i | input | 1 | A possible return has resolved taken |
| ret_pc_i | input | ADDR_W | Address of the possible return |
| ret_tgt_i | input | ADDR_W | Actual target of the possible return |
| lkp_pc_i | input | ADDR_W | Branch address looked up at fetch |
| lkp_hit_o | output | 1 | A return prediction is available |
| lkp_tgt_o | output | ADDR_W | Predicted return address (stack top) |
| lkp_fn_o | output | ADDR_W | Callee target recorded with the stack top |

## Verification
The checker assumes that `call_len_i` holds only 2, 4 or 6 whenever a call is valid. Every vector and directed step in the bench uses those three lengths. The assertions treat call and return reports as single-cycle pulses that are sampled once per edge. The bench raises each report for exactly one clock and then drops it before it checks the lookup result. Return targets are chosen so that a match or a miss is intended in every case: duplicate return addresses appear only in the topmost-match test, and aliasing cache indices appear only in the direct-mapping test.

// File: rtl/call_ret_pkg.sv
package call_ret_pkg;

   typedef enum logic [2:0] {
      ILEN_HALF  = 3'd2,
      ILEN_WORD  = 3'd4,
      ILEN_SIXB  = 3'd6
   } ilen_e;

   function automatic logic ilen_legal(input logic [2:0] len);
      return (len == ILEN_HALF) || (len == ILEN_WORD) || (len == ILEN_SIXB);
   endfunction

endpackage

// File: rtl/cr_id_stack.sv
module cr_id_stack #(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        flush_i,
   input  logic                        push_i,
   input  logic [ADDR_W-1:0]           push_ra_i,
   input  logic [ADDR_W-1:0]           push_fn_i,
   input  logic                        srch_i,
   input  logic [ADDR_W-1:0]           srch_addr_i,
   output logic                        hit_o,
   output logic [ADDR_W-1:0]           top_ra_o,
   output logic [ADDR_W-1:0]           top_fn_o,
   output logic [$clog2(DEPTH+1)-1:0]  cnt_o
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH+1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("cr_id_stack: DEPTH must be a power of two, at least 2");
   end

   logic [ADDR_W-1:0] ra_q [DEPTH];
   logic [ADDR_W-1:0] fn_q [DEPTH];
   logic [PTR_W-1:0]  ptr_q, ptr_mid, ptr_nxt, top_idx;
   logic [CNT_W-1:0]  cnt_q, cnt_mid, cnt_nxt, pop_len;
   logic [DEPTH-1:0]  match;
   logic [PTR_W-1:0]  pos;

   // per-depth comparators, depth 0 is the top of stack
   for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
      localparam logic [PTR_W-1:0] OFF = PTR_W'(k + 1);
      logic [PTR_W-1:0] slot;
      assign slot     = ptr_q - OFF;
      assign match[k] = (CNT_W'(k) < cnt_q) && (ra_q[slot] == srch_addr_i);
   end

   // topmost match wins: scan from the bottom so the smallest depth overrides
   always_comb begin
      hit_o = 1'b0;
      pos   = '0;
      for (int k = DEPTH - 1; k >= 0; k--) begin
         if (srch_i && match[k]) begin
            hit_o = 1'b1;
            pos   = PTR_W'(k);
         end
      end
   end

   // pop first, then push
   always_comb begin
      pop_len = hit_o ? (CNT_W'(pos) + CNT_W'(1)) : '0;
      cnt_mid = cnt_q - pop_len;
      ptr_mid = ptr_q - PTR_W'(pop_len);
      if (push_i) begin
         cnt_nxt = (cnt_mid == FULL) ? FULL : cnt_mid + CNT_W'(1);
         ptr_nxt = ptr_mid + PTR_W'(1);
      end else begin
         cnt_nxt = cnt_mid;
         ptr_nxt = ptr_mid;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ptr_q <= '0;
      end else if (flush_i) begin
         cnt_q <= '0;
         ptr_q <= '0;
      end else begin
         cnt_q <= cnt_nxt;
         ptr_q <= ptr_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (push_i && !flush_i) begin
         ra_q[ptr_mid] <= push_ra_i;
         fn_q[ptr_mid] <= push_fn_i;
      end
   end

   assign top_idx  = ptr_q - PTR_W'(1);
   assign top_ra_o = ra_q[top_idx];
   assign top_fn_o = fn_q[top_idx];
   assign cnt_o    = cnt_q;

endmodule

// File: rtl/cr_ret_cache.sv
module cr_ret_cache #(
   parameter int ADDR_W  = 32,
   parameter int ENTRIES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] wr_pc_i,
   input  logic [ADDR_W-1:0] rd_pc_i,
   output logic              rd_hit_o
);
   localparam int IDX_W = $clog2(ENTRIES);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0 || IDX_W + 2 > ADDR_W) begin : g_bad_entries
      $error("cr_ret_cache: ENTRIES must be a power of two that fits the address");
   end

   // bit 0 is kept in the tag so every address bit takes part in the match
   function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
      return a[IDX_W:1];
   endfunction

   function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
      return {a[ADDR_W-1:IDX_W+1], a[0]};
   endfunction

   logic [TAG_W-1:0]   tag_q [ENTRIES];
   logic [ENTRIES-1:0] vld_q;
   logic [IDX_W-1:0]   wr_idx, rd_idx;

   assign wr_idx = idx_of(wr_pc_i);
   assign rd_idx = idx_of(rd_pc_i);

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            vld_q[e] <= 1'b0;
         else if (flush_i)
            vld_q[e] <= 1'b0;
         else if (wr_i && wr_idx == IDX_W'(e))
            vld_q[e] <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (wr_i && !flush_i && wr_idx == IDX_W'(e))
            tag_q[e] <= tag_of(wr_pc_i);
      end
   end

   assign rd_hit_o = vld_q[rd_idx] && (tag_q[rd_idx] == tag_of(rd_pc_i));

endmodule

// File: rtl/call_ret_predictor.sv
module call_ret_predictor #(
   parameter int ADDR_W      = 32,
   parameter int STACK_DEPTH = 8,
   parameter int RC_ENTRIES  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              call_vld_i,
   input  logic [ADDR_W-1:0] call_pc_i,
   input  logic [2:0]        call_len_i,
   input  logic [ADDR_W-1:0] call_tgt_i,
   input  logic              ret_vld_i,
   input  logic [ADDR_W-1:0] ret_pc_i,
   input  logic [ADDR_W-1:0] ret_tgt_i,
   input  logic [ADDR_W-1:0] lkp_pc_i,
   output logic              lkp_hit_o,
   output logic [ADDR_W-1:0] lkp_tgt_o,
   output logic [ADDR_W-1:0] lkp_fn_o
);
   localparam int CNT_W = $clog2(STACK_DEPTH + 1);

   logic [ADDR_W-1:0] call_ra;
   logic              push_en, srch_en, srch_hit, rc_hit;
   logic [ADDR_W-1:0] stk_top_ra, stk_top_fn;
   logic [CNT_W-1:0]  stk_cnt;

   assign call_ra = call_pc_i + ADDR_W'(call_len_i);
   assign push_en = call_vld_i && !flush_i;
   assign srch_en = ret_vld_i && !flush_i;

   cr_id_stack #(.ADDR_W(ADDR_W), .DEPTH(STACK_DEPTH)) u_stack (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush_i     (flush_i),
      .push_i      (push_en),
      .push_ra_i   (call_ra),
      .push_fn_i   (call_tgt_i),
      .srch_i      (srch_en),
      .srch_addr_i (ret_tgt_i),
      .hit_o       (srch_hit),
      .top_ra_o    (stk_top_ra),
      .top_fn_o    (stk_top_fn),
      .cnt_o       (stk_cnt)
   );

   cr_ret_cache #(.ADDR_W(ADDR_W), .ENTRIES(RC_ENTRIES)) u_rcache (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush_i  (flush_i),
      .wr_i     (srch_hit),
      .wr_pc_i  (ret_pc_i),
      .rd_pc_i  (lkp_pc_i),
      .rd_hit_o (rc_hit)
   );

   assign lkp_hit_o = rc_hit && (stk_cnt != '0);
   assign lkp_tgt_o = stk_top_ra;
   assign lkp_fn_o  = stk_top_fn;

endmodule

// File: rtl/call_ret_predictor_chk.sv
module call_ret_predictor_chk #(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 8
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        flush_i,
   input logic                        call_vld_i,
   input logic [ADDR_W-1:0]           call_pc_i,
   input logic [2:0]                  call_len_i,
   input logic                        ret_vld_i,
   input logic                        srch_hit,
   input logic [$clog2(DEPTH+1)-1:0]  stk_cnt,
   input logic [ADDR_W-1:0]           stk_top_ra,
   input logic                        lkp_hit_o
);
   import call_ret_pkg::*;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   a_r1_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
      call_vld_i |-> ilen_legal(call_len_i));

   a_r2_top_is_new_ra: assert property (@(posedge clk) disable iff (!rst_n)
      (call_vld_i && !flush_i) |=> stk_top_ra == $past(call_pc_i + ADDR_W'(call_len_i)));

   a_r3_full_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
      (call_vld_i && !ret_vld_i && !flush_i && stk_cnt == FULL) |=> stk_cnt == FULL);

   a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (call_vld_i && !ret_vld_i && !flush_i && stk_cnt != FULL) |=>
         stk_cnt == $past(stk_cnt) + CNT_W'(1));

   a_r5_miss_keeps_stack: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_vld_i && !srch_hit && !call_vld_i && !flush_i) |=> $stable(stk_cnt));

   a_r7_empty_no_pred: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_cnt == '0) |-> !lkp_hit_o);

   a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (stk_cnt == '0) && !lkp_hit_o);

endmodule

bind call_ret_predictor call_ret_predictor_chk #(.ADDR_W(ADDR_W), .DEPTH(STACK_DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flush_i    (flush_i),
   .call_vld_i (call_vld_i),
   .call_pc_i  (call_pc_i),
   .call_len_i (call_len_i),
   .ret_vld_i  (ret_vld_i),
   .srch_hit   (srch_hit),
   .stk_cnt    (stk_cnt),
   .stk_top_ra (stk_top_ra),
   .lkp_hit_o  (lkp_hit_o)
);

// File: tb/call_ret_predictor_bench.sv
`timescale 1ns/1ps
module call_ret_predictor_bench;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush_i = 1'b0;
   logic          call_vld_i = 1'b0;
   logic [AW-1:0] call_pc_i = '0;
   logic [2:0]    call_len_i = 3'd4;
   logic [AW-1:0] call_tgt_i = '0;
   logic          ret_vld_i = 1'b0;
   logic [AW-1:0] ret_pc_i = '0;
   logic [AW-1:0] ret_tgt_i = '0;
   logic [AW-1:0] lkp_pc_i = '0;
   logic          lkp_hit_o;
   logic [AW-1:0] lkp_tgt_o;
   logic [AW-1:0] lkp_fn_o;

   int  n_run = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #2 clk = ~clk;

   call_ret_predictor u_call_ret_predictor (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
      .call_vld_i(call_vld_i), .call_pc_i(call_pc_i), .call_len_i(call_len_i),
      .call_tgt_i(call_tgt_i), .ret_vld_i(ret_vld_i), .ret_pc_i(ret_pc_i),
      .ret_tgt_i(ret_tgt_i), .lkp_pc_i(lkp_pc_i), .lkp_hit_o(lkp_hit_o),
      .lkp_tgt_o(lkp_tgt_o), .lkp_fn_o(lkp_fn_o)
   );

   typedef struct packed {
      logic [23:0]   rq;
      logic          cv;
      logic [AW-1:0] cpc;
      logic [2:0]    cl;
      logic [AW-1:0] ct;
      logic          rv;
      logic [AW-1:0] rpc;
      logic [AW-1:0] rt;
      logic [AW-1:0] lpc;
      logic          eh;
      logic [AW-1:0] et;
      logic [AW-1:0] ef;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VECS [NV] = '{
      '{"R2 ", 1'b1, 32'h1000, 3'd4, 32'h2000, 1'b0, 32'h0,   32'h0,    32'h100, 1'b0, 32'h0,    32'h0},
      '{"R7 ", 1'b0, 32'h0,    3'd4, 32'h0,    1'b1, 32'h100, 32'h1004, 32'h100, 1'b0, 32'h0,    32'h0},
      '{"R1 ", 1'b1, 32'h3000, 3'd2, 32'h4000, 1'b0, 32'h0,   32'h0,    32'h100, 1'b1, 32'h3002, 32'h4000},
      '{"R1 ", 1'b1, 32'h5000, 3'd6, 32'h6000, 1'b0, 32'h0,   32'h0,    32'h100, 1'b1, 32'h5006, 32'h6000},
      '{"R2 ", 1'b1, 32'h7000, 3'd4, 32'h8000, 1'b0, 32'h0,   32'h0,    32'h100, 1'b1, 32'h7004, 32'h8000},
      '{"R4 ", 1'b0, 32'h0,    3'd4, 32'h0,    1'b1, 32'h204, 32'h5006, 32'h100, 1'b1, 32'h3002, 32'h4000},
      '{"R5 ", 1'b0, 32'h0,    3'd4, 32'h0,    1'b1, 32'h208, 32'h9998, 32'h208, 1'b0, 32'h0,    32'h0},
      '{"R5 ", 1'b0, 32'h0,    3'd4, 32'h0,    1'b0, 32'h0,   32'h0,    32'h100, 1'b1, 32'h3002, 32'h4000},
      '{"R8 ", 1'b1, 32'hA000, 3'd4, 32'hA100, 1'b1, 32'h204, 32'h3002, 32'h204, 1'b1, 32'hA004, 32'hA100},
      '{"R6 ", 1'b0, 32'h0,    3'd4, 32'h0,    1'b0, 32'h0,   32'h0,    32'h120, 1'b0, 32'h0,    32'h0},
      '{"R6 ", 1'b0, 32'h0,    3'd4, 32'h0,    1'b1, 32'h120, 32'hA004, 32'h120, 1'b0, 32'h0,    32'h0},
      '{"R6 ", 1'b1, 32'hB000, 3'd2, 32'hB100, 1'b0, 32'h0,   32'h0,    32'h100, 1'b0, 32'h0,    32'h0},
      '{"R6 ", 1'b0, 32'h0,    3'd4, 32'h0,    1'b0, 32'h0,   32'h0,    32'h120, 1'b1, 32'hB002, 32'hB100}
   };

   // called at a falling edge; returns at the next falling edge with strobes dropped
   task automatic step(input logic fl, input logic cv, input logic [AW-1:0] cpc,
                       input logic [2:0] cl, input logic [AW-1:0] ct,
                       input logic rv, input logic [AW-1:0] rpc,
                       input logic [AW-1:0] rt, input logic [AW-1:0] lpc);
      flush_i    = fl;
      call_vld_i = cv;
      call_pc_i  = cpc;
      call_len_i = cl;
      call_tgt_i = ct;
      ret_vld_i  = rv;
      ret_pc_i   = rpc;
      ret_tgt_i  = rt;
      lkp_pc_i   = lpc;
      @(posedge clk);
      @(negedge clk);
      flush_i    = 1'b0;
      call_vld_i = 1'b0;
      ret_vld_i  = 1'b0;
   endtask

   task automatic chk(input string rq, input logic eh, input logic [AW-1:0] et,
                      input logic [AW-1:0] ef);
      n_run++;
      if (lkp_hit_o !== eh) begin
         n_fail++;
         $display("FAIL %s: hit=%0b expected %0b (pc %h)", rq, lkp_hit_o, eh, lkp_pc_i);
      end else if (eh && (lkp_tgt_o !== et || lkp_fn_o !== ef)) begin
         n_fail++;
         $display("FAIL %s: tgt=%h fn=%h expected tgt=%h fn=%h", rq, lkp_tgt_o, lkp_fn_o, et, ef);
      end
   endtask

   task automatic idle_chk(input string rq, input logic [AW-1:0] lpc, input logic eh,
                           input logic [AW-1:0] et, input logic [AW-1:0] ef);
      step(1'b0, 1'b0, '0, 3'd4, '0, 1'b0, '0, '0, lpc);
      chk(rq, eh, et, ef);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: nothing known after reset
      lkp_pc_i = 32'h100;
      #0.5;
      chk("R10", 1'b0, '0, '0);

      for (int i = 0; i < NV; i++) begin
         step(1'b0, VECS[i].cv, VECS[i].cpc, VECS[i].cl, VECS[i].ct,
              VECS[i].rv, VECS[i].rpc, VECS[i].rt, VECS[i].lpc);
         chk(string'(VECS[i].rq), VECS[i].eh, VECS[i].et, VECS[i].ef);
      end

      // R9: flush wins over a call in the same cycle, and clears the cache
      step(1'b1, 1'b1, 32'hF000, 3'd4, 32'hF100, 1'b0, '0, '0, 32'h120);
      chk("R9", 1'b0, '0, '0);
      step(1'b0, 1'b1, 32'hE000, 3'd4, 32'hE100, 1'b0, '0, '0, 32'h120);
      chk("R9", 1'b0, '0, '0);
      step(1'b0, 1'b0, '0, 3'd4, '0, 1'b1, 32'h100, 32'hE004, 32'h100);
      chk("R9", 1'b0, '0, '0);

      // R3: nine pushes into eight slots
      for (int k = 0; k < 9; k++)
         step(1'b0, 1'b1, 32'h10000 + 32'(k) * 32'h100, 3'd4, 32'h20000 + 32'(k),
              1'b0, '0, '0, 32'h100);
      chk("R3", 1'b1, 32'h10804, 32'h20008);
      step(1'b0, 1'b0, '0, 3'd4, '0, 1'b1, 32'h100, 32'h10804, 32'h100);
      chk("R3", 1'b1, 32'h10704, 32'h20007);
      step(1'b0, 1'b0, '0, 3'd4, '0, 1'b1, 32'h100, 32'h10004, 32'h100);
      chk("R3", 1'b1, 32'h10704, 32'h20007);
      step(1'b0, 1'b0, '0, 3'd4, '0, 1'b1, 32'h100, 32'h10104, 32'h100);
      chk("R3", 1'b0, '0, '0);
      step(1'b0, 1'b1, 32'h30000, 3'd4, 32'h31000, 1'b0, '0, '0, 32'h100);
      chk("R5", 1'b1, 32'h30004, 32'h31000);

      // R4: duplicate return addresses, topmost one is taken
      step(1'b1, 1'b0, '0, 3'd4, '0, 1'b0, '0, '0, 32'h100);
      step(1'b0, 1'b1, 32'h40000, 3'd4, 32'h41000, 1'b0, '0, '0, 32'h100);
      step(1'b0, 1'b0, '0, 3'd4, '0, 1'b1, 32'h100, 32'h40004, 32'h100);
      step(1'b0, 1'b1, 32'h40000, 3'd4, 32'h50000, 1'b0, '0, '0, 32'h100);
      step(1'b0, 1'b1, 32'h40000, 3'd4, 32'h51000, 1'b0, '0, '0, 32'h100);
      step(1'b0, 1'b1, 32'h60000, 3'd2, 32'h52000, 1'b0, '0, '0, 32'h100);
      chk("R2", 1'b1, 32'h60002, 32'h52000);
      step(1'b0, 1'b0, '0, 3'd4, '0, 1'b1, 32'h100, 32'h40004, 32'h100);
      chk("R4", 1'b1, 32'h40004, 32'h50000);
      idle_chk("R4", 32'h100, 1'b1, 32'h40004, 32'h50000);

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule